// File: doc/BRIEF.md
# Serial-Grant Priority Bus Arbiter

This block decides which of several bus masters may drive a shared bus. All masters raise their requests onto one combined request line that feeds a small central controller. When that line goes high, the controller sends out a single grant. The grant enters the chain at master 0 and travels from master to master. A master that is requesting keeps the grant. A master that is not requesting passes it to the next one. Priority therefore depends only on a master's place in the chain: the lower the index, the higher the priority.

A master that takes the grant latches ownership. It keeps ownership until someone pulses the shared release line. Requests that appear meanwhile, even from higher-priority masters, do not take the bus away. After a release, the controller drops its grant for at least one cycle before it offers the bus again. Nothing is done to make the scheme fair, so a high-priority master that keeps requesting can lock the lower ones out indefinitely.

Top module: `chain_bus_arbiter`

## Requirements
- R1: After reset, `grant_o`, `busy_o`, `own_o`, `grant_tap_o` and `grant_end_o` are all zero.
- R2: While no master owns the bus and `grant_o` is low, `grant_o` stays low as long as `req_i` is all zero. It rises on the clock edge after any bit of `req_i` is high.
- R3: Suppose `grant_o` is high, no master owns the bus, and at least one request is present. At the next edge, ownership goes to the requesting master with the lowest index. `own_o` bit i is 1 exactly when master i owns the bus, and `busy_o` rises on that same edge.
- R4: The grant reaches master i (`grant_tap_o[i]`) only when `grant_o` is high and every master with a lower index is neither requesting nor owning. `grant_end_o` is high when the grant has passed all masters.
- R5: An owner keeps ownership, and `grant_o` stays high, until the release line is seen. This holds even if higher-priority masters start requesting or the owner drops its own request.
- R6: At most one bit of `own_o` is ever set.
- R7: When `release_i` is high while the bus is owned, the next edge clears `own_o`, `busy_o` and `grant_o`. `grant_o` then stays low for that one cycle before the bus can be offered again.
- R8: When the bus is not owned, `release_i` has no effect, and a grant that is already on offer still goes to a requester.
- R9: If every request goes away while the grant is on offer and no master owns the bus, `grant_o` falls at the next edge and nobody becomes owner.
- R10: A master can be starved: while a higher-priority master requests at every offer, a lower-priority master never becomes owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Per-master bus request, bit 0 has the highest priority |
| release_i | input | 1 | Shared release line: the owner has finished |
| grant_o | output | 1 | Grant from the controller into master 0 |
| grant_tap_o | output | NUM_MASTERS | Grant as it arrives at each master |
| grant_end_o | output | 1 | Grant passed beyond the last master |
| own_o | output | NUM_MASTERS | Latched ownership, one bit per master |
| busy_o | output | 1 | Bus currently owned |

## Verification
The bench targets pre-emption. A higher-priority master starts requesting while a low-priority master owns the bus. If the design re-evaluated the chain at that point, ownership would move or two masters would own at once, and the bench samples both `own_o` and the grant taps during that window to catch it. It also targets the one-cycle grant gap after a release: a controller that re-offered immediately would show a grant high on the cycle right after the release. It also exercises two cases around a grant with no owner. In the first, requests are withdrawn while the grant is on offer; a design that stalled there would keep the grant high. In the second, a release arrives while nothing is owned; a design that acted on it would drop the grant or lose the capture. A starvation run checks that the lowest-priority master never wins while master 0 keeps requesting. It also checks that a table of request patterns always yields the lowest-index requester as owner.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
    } ctrl_regs_t;

    typedef struct packed {
        logic own;
    } cell_regs_t;

endpackage

// File: rtl/arb_req_merge.sv
module arb_req_merge #(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic                   any_req_o
);
    // logical model of the shared wired-OR request line
    logic [NUM_MASTERS:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_or
        assign acc[i+1] = acc[i] | req_i[i];
    end

    assign any_req_o = acc[NUM_MASTERS];
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_req_i,
    input  logic release_i,
    output logic grant_o,
    output logic offer_o,
    output logic held_o
);
    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (any_req_i) r_d.state = ST_OFFER;
            end
            ST_OFFER: begin
                // a requester always captures while offered; otherwise withdraw
                if (any_req_i) r_d.state = ST_HELD;
                else           r_d.state = ST_IDLE;
            end
            ST_HELD: begin
                if (release_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign offer_o = (r_q.state == ST_OFFER);
    assign held_o  = (r_q.state == ST_HELD);
    assign grant_o = offer_o | held_o;
endmodule

// File: rtl/arb_chain_cell.sv
module arb_chain_cell
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_in_i,
    input  logic req_i,
    input  logic offer_i,
    input  logic held_i,
    input  logic release_i,
    output logic grant_out_o,
    output logic own_o
);
    cell_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.own) begin
            if (held_i && release_i) r_d.own = 1'b0;
        end else if (grant_in_i && req_i && offer_i) begin
            r_d.own = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{own: 1'b0};
        else        r_q <= r_d;
    end

    // a requesting or owning master absorbs the grant
    assign grant_out_o = grant_in_i & ~req_i & ~r_q.own;
    assign own_o       = r_q.own;
endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic                   release_i,
    output logic                   grant_o,
    output logic [NUM_MASTERS-1:0] grant_tap_o,
    output logic                   grant_end_o,
    output logic [NUM_MASTERS-1:0] own_o,
    output logic                   busy_o
);
    logic                   any_req;
    logic                   offer;
    logic                   held;
    logic                   grant_root;
    logic [NUM_MASTERS-1:0] chain_in;
    logic [NUM_MASTERS-1:0] chain_out;

    arb_req_merge #(.NUM_MASTERS(NUM_MASTERS)) i_merge (
        .req_i     (req_i),
        .any_req_o (any_req)
    );

    arb_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req_i (any_req),
        .release_i (release_i),
        .grant_o   (grant_root),
        .offer_o   (offer),
        .held_o    (held)
    );

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign chain_in[i] = grant_root;
        end else begin : g_link
            assign chain_in[i] = chain_out[i-1];
        end

        arb_chain_cell i_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant_in_i  (chain_in[i]),
            .req_i       (req_i[i]),
            .offer_i     (offer),
            .held_i      (held),
            .release_i   (release_i),
            .grant_out_o (chain_out[i]),
            .own_o       (own_o[i])
        );
    end

    assign grant_o     = grant_root;
    assign grant_tap_o = chain_in;
    assign grant_end_o = chain_out[NUM_MASTERS-1];
    assign busy_o      = held;
endmodule

// File: rtl/chain_bus_arbiter_chk.sv
module chain_bus_arbiter_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req_i,
    input logic                   release_i,
    input logic                   grant_o,
    input logic [NUM_MASTERS-1:0] own_o,
    input logic                   busy_o
);
    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_o));

    // R2
    offer_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_o && own_o == '0 && req_i != '0) |=> grant_o);

    // R2
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_o && req_i == '0) |=> !grant_o);

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && own_o == '0 && req_i != '0) |=> ($countones(own_o) == 1 && busy_o));

    // R5
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o != '0 && !release_i) |=> ($stable(own_o) && grant_o));

    // R7
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o != '0 && release_i) |=> (own_o == '0 && !grant_o && !busy_o));

    // R9
    withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && own_o == '0 && req_i == '0) |=> (!grant_o && own_o == '0));
endmodule

bind chain_bus_arbiter chain_bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .release_i (release_i),
    .grant_o   (grant_o),
    .own_o     (own_o),
    .busy_o    (busy_o)
);

// File: tb/test_chain_bus_arbiter.sv
module test_chain_bus_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         release_i = 1'b0;
    logic         grant_o;
    logic [N-1:0] grant_tap_o;
    logic         grant_end_o;
    logic [N-1:0] own_o;
    logic         busy_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    chain_bus_arbiter #(.NUM_MASTERS(N)) i_chain_bus_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .release_i   (release_i),
        .grant_o     (grant_o),
        .grant_tap_o (grant_tap_o),
        .grant_end_o (grant_end_o),
        .own_o       (own_o),
        .busy_o      (busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {req, expected owner, expected taps while held}
    localparam int NVEC = 8;
    localparam logic [11:0] VEC [NVEC] = '{
        {4'b0001, 4'b0001, 4'b0001},
        {4'b0010, 4'b0010, 4'b0011},
        {4'b0100, 4'b0100, 4'b0111},
        {4'b1000, 4'b1000, 4'b1111},
        {4'b1111, 4'b0001, 4'b0001},
        {4'b1100, 4'b0100, 4'b0111},
        {4'b1010, 4'b0010, 4'b0011},
        {4'b0110, 4'b0010, 4'b0011}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        release_i = 1'b1;
        req_i     = '0;
        step();
        check("R7 own cleared", own_o, 0);
        check("R7 grant dropped", grant_o, 0);
        check("R7 busy dropped", busy_o, 0);
        release_i = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 grant", grant_o, 0);
        check("R1 own", own_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 taps", {grant_end_o, grant_tap_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no request keeps the controller idle
        repeat (3) step();
        check("R2 idle grant", grant_o, 0);

        // table walk: R3, R4
        for (int v = 0; v < NVEC; v++) begin
            req_i = VEC[v][11:8];
            step();
            check("R2 grant rises", grant_o, 1);
            check("R3 no owner yet", own_o, 0);
            step();
            check("R3 lowest requester owns", own_o, VEC[v][7:4]);
            check("R3 busy", busy_o, 1);
            check("R4 taps", grant_tap_o, VEC[v][3:0]);
            check("R6 single owner", $countones(own_o), 1);
            release_bus();
        end

        // R5: low-priority owner holds against higher request
        req_i = 4'b1000;
        step(); step();
        check("R5 owner 3", own_o, 4'b1000);
        check("R4 grant end low", grant_end_o, 0);
        req_i = 4'b1001;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R5 owner kept", own_o, 4'b1000);
            check("R4 taps absorbed at 0", grant_tap_o, 4'b0001);
        end
        req_i = 4'b0001;   // owner drops its own request
        step();
        check("R5 owner kept after drop", own_o, 4'b1000);
        check("R5 grant held", grant_o, 1);
        // R7: release, one-cycle gap, then reoffer
        release_i = 1'b1;
        step();
        check("R7 own cleared", own_o, 0);
        check("R7 gap grant low", grant_o, 0);
        release_i = 1'b0;
        step();
        check("R7 reoffer", grant_o, 1);
        step();
        check("R7 new owner 0", own_o, 4'b0001);
        release_bus();
        step();

        // R8: release while idle has no effect; release during offer ignored
        release_i = 1'b1;
        step();
        check("R8 idle grant", grant_o, 0);
        req_i = 4'b0100;
        step();
        check("R8 offer despite release", grant_o, 1);
        step();
        check("R8 capture despite release", own_o, 4'b0100);
        release_i = 1'b0;
        release_bus();
        step();

        // R9: requests vanish during offer
        req_i = 4'b0010;
        step();
        check("R9 offered", grant_o, 1);
        req_i = '0;
        step();
        check("R9 grant withdrawn", grant_o, 0);
        check("R9 no owner", own_o, 0);
        check("R4 end with no requester", grant_end_o, 0);

        // R10: starvation of master 3
        for (int k = 0; k < 5; k++) begin
            req_i = 4'b1001;
            step(); step();
            check("R10 master 3 starved", own_o, 4'b0001);
            release_i = 1'b1;
            step();
            release_i = 1'b0;
        end
        req_i = '0;
        step();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule